// File: doc/BRIEF.md
# Key-Sequence Register Lock Unit

This unit keeps two control registers of a flash controller, a main control register and an option control register, write-protected until software proves intent. Each register carries a lock flag that is set out of reset. The flag drops only after a dedicated key register receives a specific pair of 32-bit words, first word then second word, with no other key write between them. The main register and the option register each have their own key register and their own key pair. The option register can be unlocked only while the main register is unlocked.

Software talks to the unit through a single-cycle write port: an address, a data word and a write strobe. The unit drives the lock flags, a sticky key-fault flag and the current contents of both control registers to the rest of the controller. A wrong key word, or the right words in the wrong order, latches a fault on that channel. The channel then stays locked and ignores further key words until reset. Software relocks a register by writing it with its lock bit set.

Top module: `key_lock_unit`

## Requirements
- R1: While reset is held and after it is released, both registers are locked, key_fault is 0, main_ctrl reads 0x80000000 and opt_ctrl reads 0x00000001.
- R2: The main lock clears after a write of 0x45670123 to address 0 (main key) followed by a write of 0xCDEF89AB to address 0. Both words are needed: main_locked is still 1 after the first word alone.
- R3: A write to address 1 (main control) while the main lock is set leaves main_ctrl unchanged.
- R4: While the main lock is clear, a write to address 1 stores bits 30:0. A 1 in bit 31 sets the main lock again, and main_ctrl bit 31 always reads the lock state.
- R5: On either channel, a key word that is not the expected one (wrong value, or second key first) leaves that register locked and sets key_fault. That channel then ignores all key writes, including a correct pair, until reset. The other channel keeps working.
- R6: A key write to an already unlocked channel has no effect: the register stays unlocked and no fault is raised.
- R7: The option lock clears after 0x08192A3B and then 0x4C5D6E7F are written to address 2 (option key), but only while the main lock is clear. Option key writes made while the main lock is set change nothing and raise no fault.
- R8: Writes to address 3 (option control) are ignored while the option lock is set. While it is clear, bits 31:1 are stored and a 1 in bit 0 sets the option lock again. opt_ctrl bit 0 reads the option lock state.
- R9: Setting the main lock also sets the option lock and drops any half-entered option key pair. The option register is never unlocked while the main register is locked.
- R10: Writes to addresses other than a channel's key register, made between its first and second key word, do not disturb that key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W (2) | Register select: 0 main key, 1 main control, 2 option key, 3 option control |
| wr_data | input | 32 | Write data |
| main_locked | output | 1 | Main control register is locked |
| opt_locked | output | 1 | Option control register is locked |
| key_fault | output | 1 | Sticky flag: a bad key sequence was seen on either channel |
| main_ctrl | output | 32 | Main control contents, bit 31 is the lock flag |
| opt_ctrl | output | 32 | Option control contents, bit 0 is the lock flag |

## Verification
Assertions check several invariants on every cycle. A latched fault never clears before reset. A lock can only drop from the half-entered key state. An unlocked channel stays unlocked unless it is relocked or its enable is removed. Stored register bits never change while locked. The option register is never open while the main register is locked, and no option fault can arise while the main lock is set. Whether the key values are the right constants, what a given write stores, and whether a fault really blocks a later correct pair can only be seen in the bench's scenarios. The bench runs directed sequences and a seeded random mix of writes, correct key pairs and resets, and compares the results against a reference model of the requirements.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 32;

    // register map
    localparam logic [ADDR_W-1:0] A_MAIN_KEY  = 2'd0;
    localparam logic [ADDR_W-1:0] A_MAIN_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] A_OPT_KEY   = 2'd2;
    localparam logic [ADDR_W-1:0] A_OPT_CTRL  = 2'd3;

    // key pairs
    localparam logic [DATA_W-1:0] MAIN_KEY_A = 32'h4567_0123;
    localparam logic [DATA_W-1:0] MAIN_KEY_B = 32'hCDEF_89AB;
    localparam logic [DATA_W-1:0] OPT_KEY_A  = 32'h0819_2A3B;
    localparam logic [DATA_W-1:0] OPT_KEY_B  = 32'h4C5D_6E7F;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2,
        KS_FAULT  = 2'd3
    } key_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    // next state of a key channel on one key write
    function automatic key_state_e key_step(input key_state_e cur,
                                            input logic [DATA_W-1:0] d,
                                            input logic [DATA_W-1:0] ka,
                                            input logic [DATA_W-1:0] kb);
        key_state_e nxt;
        case (cur)
            KS_LOCKED: nxt = (d == ka) ? KS_HALF : KS_FAULT;
            KS_HALF:   nxt = (d == kb) ? KS_OPEN : KS_FAULT;
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/key_seq_fsm.sv
module key_seq_fsm
    import lock_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_A = 32'h0,
    parameter logic [DATA_W-1:0] KEY_B = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              key_we,
    input  logic [DATA_W-1:0] key_data,
    input  logic              relock,
    output logic              locked,
    output logic              fault
);

    key_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= KS_LOCKED;
        else if (state_q == KS_FAULT)
            state_q <= KS_FAULT;
        else if (!enable || relock)
            state_q <= KS_LOCKED;
        else if (key_we)
            state_q <= key_step(state_q, key_data, KEY_A, KEY_B);
    end

    assign locked = (state_q != KS_OPEN);
    assign fault  = (state_q == KS_FAULT);

    // R5
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    // R2
    unlock_from_half_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> ($past(state_q) == KS_HALF) && $past(key_we));

    // R6
    open_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!locked && enable && !relock) |=> !locked);

endmodule

// File: rtl/lock_ctrl_reg.sv
module lock_ctrl_reg
    import lock_pkg::*;
#(
    parameter int W        = DATA_W,
    parameter int LOCK_BIT = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_sel,
    input  logic [W-1:0] wdata,
    input  logic         locked,
    output logic         relock_req,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] KEEP_MASK = ~(W'(1) << LOCK_BIT);

    logic [W-1:0] stored_q;
    logic         accept;

    assign accept     = wr_sel && !locked;
    assign relock_req = accept && wdata[LOCK_BIT];

    always_ff @(posedge clk) begin
        if (rst)
            stored_q <= '0;
        else if (accept)
            stored_q <= wdata & KEEP_MASK;
    end

    always_comb begin
        value           = stored_q;
        value[LOCK_BIT] = locked;
    end

    // R3
    locked_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(stored_q));

endmodule

// File: rtl/key_lock_unit.sv
module key_lock_unit
    import lock_pkg::*;
#(
    parameter int AW            = ADDR_W,
    parameter int MAIN_LOCK_BIT = 31,
    parameter int OPT_LOCK_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              main_locked,
    output logic              opt_locked,
    output logic              key_fault,
    output logic [DATA_W-1:0] main_ctrl,
    output logic [DATA_W-1:0] opt_ctrl
);

    reg_wr_t bus;
    logic    main_relock, opt_relock;
    logic    main_fault, opt_fault;
    logic    opt_enable;

    assign bus.we   = wr_en;
    assign bus.addr = wr_addr;
    assign bus.data = wr_data;

    // option channel only runs while main is open and not relocking
    assign opt_enable = !main_locked && !main_relock;

    key_seq_fsm #(.KEY_A(MAIN_KEY_A), .KEY_B(MAIN_KEY_B)) u_main_keys (
        .clk      (clk),
        .rst      (rst),
        .enable   (1'b1),
        .key_we   (bus.we && bus.addr == A_MAIN_KEY),
        .key_data (bus.data),
        .relock   (main_relock),
        .locked   (main_locked),
        .fault    (main_fault)
    );

    key_seq_fsm #(.KEY_A(OPT_KEY_A), .KEY_B(OPT_KEY_B)) u_opt_keys (
        .clk      (clk),
        .rst      (rst),
        .enable   (opt_enable),
        .key_we   (bus.we && bus.addr == A_OPT_KEY),
        .key_data (bus.data),
        .relock   (opt_relock),
        .locked   (opt_locked),
        .fault    (opt_fault)
    );

    lock_ctrl_reg #(.W(DATA_W), .LOCK_BIT(MAIN_LOCK_BIT)) u_main_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_sel     (bus.we && bus.addr == A_MAIN_CTRL),
        .wdata      (bus.data),
        .locked     (main_locked),
        .relock_req (main_relock),
        .value      (main_ctrl)
    );

    lock_ctrl_reg #(.W(DATA_W), .LOCK_BIT(OPT_LOCK_BIT)) u_opt_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_sel     (bus.we && bus.addr == A_OPT_CTRL),
        .wdata      (bus.data),
        .locked     (opt_locked),
        .relock_req (opt_relock),
        .value      (opt_ctrl)
    );

    assign key_fault = main_fault || opt_fault;

    // R9
    opt_needs_main_chk: assert property (@(posedge clk) disable iff (rst)
        !opt_locked |-> !main_locked);

    // R7
    opt_no_fault_when_main_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (main_locked && !opt_fault) |=> !opt_fault);

endmodule

// File: tb/sim_key_lock_unit.sv
module sim_key_lock_unit;

    localparam logic [31:0] MK1 = 32'h4567_0123;
    localparam logic [31:0] MK2 = 32'hCDEF_89AB;
    localparam logic [31:0] OK1 = 32'h0819_2A3B;
    localparam logic [31:0] OK2 = 32'h4C5D_6E7F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        main_locked, opt_locked, key_fault;
    logic [31:0] main_ctrl, opt_ctrl;

    int checks = 0;
    int errors = 0;

    // model: 0 locked, 1 half, 2 open, 3 fault
    int          m_mst, m_ost;
    logic [31:0] m_mdat, m_odat;

    always #4 clk = ~clk;

    key_lock_unit u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .main_locked(main_locked), .opt_locked(opt_locked), .key_fault(key_fault),
        .main_ctrl(main_ctrl), .opt_ctrl(opt_ctrl)
    );

    function automatic int key_adv(int st, logic [31:0] d, logic [31:0] ka, logic [31:0] kb);
        if (st == 0) return (d == ka) ? 1 : 3;
        if (st == 1) return (d == kb) ? 2 : 3;
        return st;
    endfunction

    function automatic logic [31:0] exp_main();
        return {(m_mst != 2), m_mdat[30:0]};
    endfunction

    function automatic logic [31:0] exp_opt();
        return {m_odat[31:1], (m_ost != 2)};
    endfunction

    task automatic model_reset();
        m_mst = 0; m_ost = 0; m_mdat = '0; m_odat = '0;
    endtask

    task automatic model_write(logic [1:0] a, logic [31:0] d);
        bit mopen = (m_mst == 2);
        case (a)
            2'd0: m_mst = key_adv(m_mst, d, MK1, MK2);
            2'd1: if (mopen) begin
                m_mdat = d & 32'h7FFF_FFFF;
                if (d[31]) begin
                    m_mst = 0;
                    if (m_ost != 3) m_ost = 0;
                end
            end
            2'd2: if (mopen) m_ost = key_adv(m_ost, d, OK1, OK2);
            default: if (m_ost == 2) begin
                m_odat = d & 32'hFFFF_FFFE;
                if (d[0]) m_ost = 0;
            end
        endcase
    endtask

    task automatic chk(string tag);
        logic [34:0] act, exp;
        act = {main_locked, opt_locked, key_fault};
        exp = {(m_mst != 2), (m_ost != 2), (m_mst == 3 || m_ost == 3)};
        checks++;
        if (act[2:0] !== exp[2:0] || main_ctrl !== exp_main() || opt_ctrl !== exp_opt()) begin
            errors++;
            $display("FAIL %s: act locks/fault=%b main=%h opt=%h exp locks/fault=%b main=%h opt=%h",
                     tag, act[2:0], main_ctrl, opt_ctrl, exp[2:0], exp_main(), exp_opt());
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        model_reset();
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d, string tag);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        model_write(a, d);
        chk(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        model_reset();
        @(negedge clk); @(negedge clk);
        chk("R1 during reset");
        do_reset();
        chk("R1 after reset");

        wr(2'd1, 32'h0000_00FF, "R3 ctrl write while locked");
        wr(2'd2, OK1, "R7 opt key with main locked");
        wr(2'd2, OK2, "R7 opt key with main locked");
        wr(2'd0, MK1, "R2 first key only");
        wr(2'd3, 32'h0000_0F00, "R10 other write between keys");
        wr(2'd0, MK2, "R2 R10 second key unlocks");
        wr(2'd0, 32'h0000_1234, "R6 key write when open");
        wr(2'd1, 32'h0000_1234, "R4 ctrl store");
        wr(2'd3, 32'h0000_00F0, "R8 opt ctrl write while locked");
        wr(2'd2, OK1, "R7 opt first key");
        wr(2'd2, OK2, "R7 opt unlock");
        wr(2'd2, OK1, "R6 opt key when open");
        wr(2'd3, 32'h0000_00F0, "R8 opt ctrl store");
        wr(2'd3, 32'h0000_00F1, "R8 opt relock");
        wr(2'd2, OK1, "R7 opt rekey 1");
        wr(2'd2, OK2, "R7 opt rekey 2");
        wr(2'd1, 32'h8000_0055, "R4 R9 main relock forces opt lock");
        wr(2'd0, MK2, "R5 wrong order");
        wr(2'd0, MK1, "R5 ignored after fault");
        wr(2'd0, MK2, "R5 ignored after fault");
        wr(2'd1, 32'h0000_0001, "R5 ctrl still locked");

        do_reset();
        chk("R1 reset clears fault");
        wr(2'd0, MK1, "R2 key1");
        wr(2'd0, MK2, "R2 key2");
        wr(2'd2, OK1, "R9 opt half");
        wr(2'd1, 32'h8000_0000, "R9 relock drops half opt seq");
        wr(2'd0, MK1, "R2 key1");
        wr(2'd0, MK2, "R2 key2");
        wr(2'd2, OK2, "R9 opt sequence restarted so fault");
        wr(2'd1, 32'h0000_0077, "R5 main unaffected by opt fault");

        do_reset();
        wr(2'd0, MK1, "R5 key1");
        wr(2'd0, 32'hDEAD_BEEF, "R5 wrong second key");

        for (int i = 0; i < 1500; i++) begin
            int op = $urandom % 12;
            if (op == 0) do_reset();
            else if (op == 1 || op == 2) begin
                wr(2'd0, MK1, "RND main seq");
                wr(2'd0, MK2, "RND main seq");
            end else if (op == 3 || op == 4) begin
                wr(2'd2, OK1, "RND opt seq");
                wr(2'd2, OK2, "RND opt seq");
            end else begin
                logic [1:0]  a = 2'($urandom % 4);
                logic [31:0] d = $urandom;
                int sel = $urandom % 6;
                if (sel == 0) d = MK1;
                else if (sel == 1) d = OK2;
                else if (sel == 2) d = d & 32'h7FFF_FFFE;
                wr(a, d, "RND write");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule